// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets the write cycles seen by a parallel NOR-style flash and turns keyed multi-cycle sequences into single-clock requests for the logic behind it. Each accepted write carries a 16-bit address and the low data byte. The decoder steps through a two-write unlock (AAh at 5555h, then 55h at 2AAAh). It then branches on a third write at 5555h: A0h arms a program, 80h opens a second unlock pair that leads to a sixth, erase-or-lock write, 90h enters identification mode and F0h leaves it. A lone F0h written from the idle state, at any address, also leaves identification mode.

The decoder owns no array, no timers and no status reads. It raises one of six pulse outputs one clock after the write that completes a sequence. It also latches that write's address and data onto `cmd_addr`/`cmd_data`, which hold until the next command. Writes arrive as a plain strobe, `wr_valid`, with no ready signal and so no back-pressure. A write that is presented while `busy` is high is discarded outright rather than stalled, and the host must not expect it to be replayed.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low and on the first clock after it rises, all six pulse outputs are 0 and `cmd_addr`/`cmd_data` are 0.
- R2: Every multi-cycle sequence opens with AAh written to 5555h followed by 55h written to 2AAAh; no command issues without this pair.
- R3: After the unlock pair, A0h at 5555h arms a program; the next accepted write, at any address and with any data, raises `cmd_program` one clock later, with `cmd_addr`/`cmd_data` equal to that write.
- R4: Unlock pair, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, then 10h at 5555h raises `cmd_chip_erase` one clock after the sixth write.
- R5: The same five-write prefix followed by 30h at any address raises `cmd_sector_erase`, with `cmd_addr` equal to the sixth write's address.
- R6: The same five-write prefix followed by 40h at 5555h raises `cmd_lock_enable`.
- R7: Unlock pair then 90h at 5555h raises `cmd_id_enter`; unlock pair then F0h at 5555h raises `cmd_id_exit`.
- R8: F0h written while the decoder is idle raises `cmd_id_exit` whatever the address.
- R9: A write that does not match the expected address and data at its step returns the decoder to idle with no pulse; that write is not reused as the first write of a new sequence.
- R10: A write presented while `busy` is high produces no pulse and leaves the sequence position unchanged, so the sequence resumes with the next accepted write.
- R11: At most one pulse output is high in any clock, each pulse lasts one clock per completing write, and `cmd_addr`/`cmd_data` change only in a clock where a pulse is high.
- R12: Taking `rst_n` low in the middle of a sequence discards it; a write after reset that would have completed the sequence issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One accepted bus write in this clock |
| wr_addr | input | 16 | Write address (bits 15..0) |
| wr_data | input | 8 | Low data byte of the write |
| busy | input | 1 | Embedded program or erase in progress; writes are dropped |
| cmd_program | output | 1 | Program request pulse |
| cmd_chip_erase | output | 1 | Whole-array erase request pulse |
| cmd_sector_erase | output | 1 | Sector erase request pulse |
| cmd_lock_enable | output | 1 | Boot-region lockout enable pulse |
| cmd_id_enter | output | 1 | Identification mode entry pulse |
| cmd_id_exit | output | 1 | Identification mode exit pulse |
| cmd_addr | output | 16 | Address of the write that completed the last command |
| cmd_data | output | 8 | Data of the write that completed the last command |

## Verification
The bench aims at the branch points. The sixth write is checked for each of its three outcomes, and a wrong code is sent there to show that a decoder that failed to narrow the branch would issue a stray erase. A broken unlock followed by a well-formed program tail proves that a decoder which re-used a failed write, or skipped back to a later step, would program a location it must not touch. Writes hidden under `busy`, back-to-back lone exits and a reset in the middle of an armed program cover three faults: a sequence dropped or advanced by a masked write, a pulse stretched or merged, and stale state surviving reset.

// File: rtl/fcsd_pkg.sv
package fcsd_pkg;

  localparam int NUM_CMD = 6;

  localparam logic [7:0] CODE_KEY1   = 8'hAA;
  localparam logic [7:0] CODE_KEY2   = 8'h55;
  localparam logic [7:0] CODE_PROG   = 8'hA0;
  localparam logic [7:0] CODE_ERASE  = 8'h80;
  localparam logic [7:0] CODE_IDIN   = 8'h90;
  localparam logic [7:0] CODE_IDOUT  = 8'hF0;
  localparam logic [7:0] CODE_CHIP   = 8'h10;
  localparam logic [7:0] CODE_SECTOR = 8'h30;
  localparam logic [7:0] CODE_LOCK   = 8'h40;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_PROG,
    ST_ERS3,
    ST_ERS4,
    ST_ERS5
  } seq_state_t;

  // Encoded command; value k (1..NUM_CMD) drives pulse bit k-1.
  typedef enum logic [2:0] {
    CK_NONE     = 3'd0,
    CK_ID_EXIT  = 3'd1,
    CK_ID_ENTER = 3'd2,
    CK_LOCK     = 3'd3,
    CK_SECTOR   = 3'd4,
    CK_CHIP     = 3'd5,
    CK_PROGRAM  = 3'd6
  } cmd_kind_t;

  typedef struct packed {
    logic at_a;
    logic at_b;
    logic d_key1;
    logic d_key2;
    logic d_prog;
    logic d_erase;
    logic d_idin;
    logic d_idout;
    logic d_chip;
    logic d_sector;
    logic d_lock;
  } match_t;

endpackage

// File: rtl/fcsd_match.sv
module fcsd_match
  import fcsd_pkg::*;
#(
  parameter int              ADDR_W = 16,
  parameter int              DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output match_t            m
);

  localparam int CODE_W = 8;
  logic [CODE_W-1:0] code;

  assign code = data[CODE_W-1:0];

  always_comb begin
    m          = '0;
    m.at_a     = (addr == KEY_ADDR_A);
    m.at_b     = (addr == KEY_ADDR_B);
    m.d_key1   = (code == CODE_KEY1);
    m.d_key2   = (code == CODE_KEY2);
    m.d_prog   = (code == CODE_PROG);
    m.d_erase  = (code == CODE_ERASE);
    m.d_idin   = (code == CODE_IDIN);
    m.d_idout  = (code == CODE_IDOUT);
    m.d_chip   = (code == CODE_CHIP);
    m.d_sector = (code == CODE_SECTOR);
    m.d_lock   = (code == CODE_LOCK);
  end

endmodule

// File: rtl/fcsd_seq.sv
module fcsd_seq
  import fcsd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  match_t    m,
  output cmd_kind_t kind
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    kind    = CK_NONE;
    if (accept) begin
      state_d = ST_IDLE;
      unique case (state_q)
        ST_IDLE: begin
          if (m.d_idout)              kind    = CK_ID_EXIT;
          else if (m.at_a && m.d_key1) state_d = ST_KEY1;
        end
        ST_KEY1: begin
          if (m.at_b && m.d_key2) state_d = ST_KEY2;
        end
        ST_KEY2: begin
          if (m.at_a) begin
            if (m.d_prog)       state_d = ST_PROG;
            else if (m.d_erase) state_d = ST_ERS3;
            else if (m.d_idin)  kind    = CK_ID_ENTER;
            else if (m.d_idout) kind    = CK_ID_EXIT;
          end
        end
        ST_PROG: begin
          kind = CK_PROGRAM;
        end
        ST_ERS3: begin
          if (m.at_a && m.d_key1) state_d = ST_ERS4;
        end
        ST_ERS4: begin
          if (m.at_b && m.d_key2) state_d = ST_ERS5;
        end
        ST_ERS5: begin
          if (m.at_a && m.d_chip)      kind = CK_CHIP;
          else if (m.at_a && m.d_lock) kind = CK_LOCK;
          else if (m.d_sector)         kind = CK_SECTOR;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/fcsd_issue.sv
module fcsd_issue
  import fcsd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cmd_kind_t          kind,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  output logic [NUM_CMD-1:0] pulse,
  output logic [ADDR_W-1:0]  addr_q,
  output logic [DATA_W-1:0]  data_q
);

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[g] <= 1'b0;
      else        pulse[g] <= (kind == cmd_kind_t'(g + 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (kind != CK_NONE) begin
      addr_q <= addr;
      data_q <= data;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcsd_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              cmd_program,
  output logic              cmd_chip_erase,
  output logic              cmd_sector_erase,
  output logic              cmd_lock_enable,
  output logic              cmd_id_enter,
  output logic              cmd_id_exit,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  logic               accept;
  match_t             m;
  cmd_kind_t          kind;
  logic [NUM_CMD-1:0] pulse;

  assign accept = wr_valid & ~busy;

  fcsd_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B)
  ) u_match (
    .addr(wr_addr),
    .data(wr_data),
    .m   (m)
  );

  fcsd_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .accept(accept),
    .m     (m),
    .kind  (kind)
  );

  fcsd_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
    .clk   (clk),
    .rst_n (rst_n),
    .kind  (kind),
    .addr  (wr_addr),
    .data  (wr_data),
    .pulse (pulse),
    .addr_q(cmd_addr),
    .data_q(cmd_data)
  );

  assign cmd_id_exit      = pulse[int'(CK_ID_EXIT)  - 1];
  assign cmd_id_enter     = pulse[int'(CK_ID_ENTER) - 1];
  assign cmd_lock_enable  = pulse[int'(CK_LOCK)     - 1];
  assign cmd_sector_erase = pulse[int'(CK_SECTOR)   - 1];
  assign cmd_chip_erase   = pulse[int'(CK_CHIP)     - 1];
  assign cmd_program      = pulse[int'(CK_PROGRAM)  - 1];

endmodule

// File: rtl/fcsd_checker.sv
module fcsd_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              cmd_program,
  input logic              cmd_chip_erase,
  input logic              cmd_sector_erase,
  input logic              cmd_lock_enable,
  input logic              cmd_id_enter,
  input logic              cmd_id_exit,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_data
);

  logic [5:0] p;
  assign p = {cmd_program, cmd_chip_erase, cmd_sector_erase,
              cmd_lock_enable, cmd_id_enter, cmd_id_exit};

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(p)); // R11

  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (p == '0) |-> ($stable(cmd_addr) && $stable(cmd_data))); // R11

  AST_BUSY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> (p == '0)); // R10

  AST_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (p != '0) |-> $past(wr_valid)); // R10

  AST_PROG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_program |-> (cmd_addr == $past(wr_addr) && cmd_data == $past(wr_data))); // R3

  AST_CHIP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_chip_erase |-> ($past(wr_addr) == 16'h5555 && $past(wr_data) == 8'h10)); // R4

  AST_SECTOR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sector_erase |-> (cmd_addr == $past(wr_addr) && $past(wr_data) == 8'h30)); // R5

  AST_LOCK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lock_enable |-> ($past(wr_addr) == 16'h5555 && $past(wr_data) == 8'h40)); // R6

  AST_ENTER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_id_enter |-> ($past(wr_addr) == 16'h5555 && $past(wr_data) == 8'h90)); // R7

  AST_EXIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_id_exit |-> ($past(wr_data) == 8'hF0)); // R8

endmodule

bind flash_cmd_decoder fcsd_checker u_chk (.*);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        busy;
  logic        cmd_program, cmd_chip_erase, cmd_sector_erase;
  logic        cmd_lock_enable, cmd_id_enter, cmd_id_exit;
  logic [15:0] cmd_addr;
  logic [7:0]  cmd_data;

  always #4 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .cmd_program(cmd_program),
    .cmd_chip_erase(cmd_chip_erase), .cmd_sector_erase(cmd_sector_erase),
    .cmd_lock_enable(cmd_lock_enable), .cmd_id_enter(cmd_id_enter),
    .cmd_id_exit(cmd_id_exit), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";

  // pulse order: program, chip, sector, lock, enter, exit
  logic [5:0]  exp_p = '0;
  logic [15:0] exp_a = '0;
  logic [7:0]  exp_d = '0;
  logic [23:0] hist[$];

  localparam logic [5:0] P_PROG  = 6'b100000;
  localparam logic [5:0] P_CHIP  = 6'b010000;
  localparam logic [5:0] P_SECT  = 6'b001000;
  localparam logic [5:0] P_LOCK  = 6'b000100;
  localparam logic [5:0] P_ENTER = 6'b000010;
  localparam logic [5:0] P_EXIT  = 6'b000001;

  function automatic bit is_w(logic [23:0] w, logic [15:0] a, logic [7:0] d);
    return (w[23:8] == a) && (w[7:0] == d);
  endfunction

  task automatic issue(logic [5:0] p, logic [15:0] a, logic [7:0] d);
    exp_p = p; exp_a = a; exp_d = d; hist.delete();
  endtask

  // Behavioural reference: the history of the current sequence is matched
  // against the grammar, one position at a time.
  task automatic model_write(logic [15:0] a, logic [7:0] d);
    logic [23:0] w;
    int n;
    w = {a, d};
    hist.push_back(w);
    n = hist.size();
    case (n)
      1: if (d == 8'hF0) issue(P_EXIT, a, d);
         else if (!is_w(w, 16'h5555, 8'hAA)) hist.delete();
      2: if (!is_w(w, 16'h2AAA, 8'h55)) hist.delete();
      3: if (a != 16'h5555) hist.delete();
         else if (d == 8'h90) issue(P_ENTER, a, d);
         else if (d == 8'hF0) issue(P_EXIT, a, d);
         else if (d != 8'hA0 && d != 8'h80) hist.delete();
      4: if (hist[2][7:0] == 8'hA0) issue(P_PROG, a, d);
         else if (!is_w(w, 16'h5555, 8'hAA)) hist.delete();
      5: if (!is_w(w, 16'h2AAA, 8'h55)) hist.delete();
      default: begin
        if (is_w(w, 16'h5555, 8'h10))      issue(P_CHIP, a, d);
        else if (is_w(w, 16'h5555, 8'h40)) issue(P_LOCK, a, d);
        else if (d == 8'h30)               issue(P_SECT, a, d);
        else                               hist.delete();
      end
    endcase
  endtask

  task automatic compare();
    logic [5:0] act;
    act = {cmd_program, cmd_chip_erase, cmd_sector_erase,
           cmd_lock_enable, cmd_id_enter, cmd_id_exit};
    n_checks++;
    if ({act, cmd_addr, cmd_data} !== {exp_p, exp_a, exp_d}) begin
      n_fail++;
      $display("FAIL %s: pulses=%b addr=%h data=%h expected pulses=%b addr=%h data=%h",
               cur_req, act, cmd_addr, cmd_data, exp_p, exp_a, exp_d);
    end
  endtask

  task automatic step(logic v, logic [15:0] a, logic [7:0] d, logic b, logic r);
    @(negedge clk);
    compare();
    wr_valid = v; wr_addr = a; wr_data = d; busy = b; rst_n = r;
    exp_p = '0;
    if (!r) begin
      hist.delete(); exp_a = '0; exp_d = '0;
    end else if (v && !b) begin
      model_write(a, d);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    step(1'b1, a, d, 1'b0, 1'b1);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(1'b0, 16'h0, 8'h0, 1'b0, 1'b1);
  endtask

  task automatic unlock();
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
  endtask

  task automatic erase_prefix();
    unlock();
    wr(16'h5555, 8'h80);
    unlock();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; busy = 1'b0;
    repeat (2) @(negedge clk);

    cur_req = "R1";   // reset state, then first cycle out of reset
    for (int i = 0; i < 3; i++) step(1'b0, 16'h5555, 8'hAA, 1'b0, 1'b0);
    idle(2);

    cur_req = "R3";   // R2 unlock pair then program
    unlock(); wr(16'h5555, 8'hA0); wr(16'h1234, 8'h5A); idle(2);

    cur_req = "R4";
    erase_prefix(); wr(16'h5555, 8'h10); idle(2);

    cur_req = "R5";
    erase_prefix(); wr(16'h7B00, 8'h30); idle(2);

    cur_req = "R6";
    erase_prefix(); wr(16'h5555, 8'h40); idle(2);

    cur_req = "R7";
    unlock(); wr(16'h5555, 8'h90); idle(1);
    unlock(); wr(16'h5555, 8'hF0); idle(2);

    cur_req = "R8";
    wr(16'h1357, 8'hF0); idle(1);
    wr(16'h0000, 8'hF0); wr(16'hFFFF, 8'hF0); idle(2);   // R11 back-to-back

    cur_req = "R9";   // broken unlock address, then a program tail
    wr(16'h5555, 8'hAA); wr(16'h2AAB, 8'h55);
    wr(16'h5555, 8'hA0); wr(16'h0F0F, 8'h11); idle(2);
    erase_prefix(); wr(16'h5555, 8'h20); idle(1);   // wrong sixth code
    erase_prefix(); wr(16'h1111, 8'h10); idle(1);   // chip code off-key
    wr(16'h5555, 8'hAA); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
    wr(16'h5555, 8'h90); idle(2);   // failed write is not a new start

    cur_req = "R10";  // writes hidden under busy
    wr(16'h5555, 8'hAA);
    step(1'b1, 16'h0000, 8'h77, 1'b1, 1'b1);
    wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0);
    step(1'b1, 16'h4444, 8'h22, 1'b1, 1'b1);
    wr(16'h4444, 8'h33); idle(1);
    step(1'b1, 16'h5555, 8'hF0, 1'b1, 1'b1); idle(2);

    cur_req = "R12";  // reset in an armed program
    unlock(); wr(16'h5555, 8'hA0);
    step(1'b0, 16'h0, 8'h0, 1'b0, 1'b0);
    idle(1);
    wr(16'h4000, 8'h99); idle(2);

    cur_req = "R11";  // capture held across idle and a failed sequence
    unlock(); wr(16'h3000, 8'h00); idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule